// File: doc/BRIEF.md
# Virtual Function BAR Address Decoder

This block decides whether a memory request address falls inside a BAR aperture owned by one of the enabled virtual functions of a physical function. No per-VF base address is stored. Each BAR has one shared base register pair, a size given as a power-of-two exponent, and a 32-bit or 64-bit flag. The aperture of VF number k starts at the aligned shared base plus k times the BAR size. A forward lookup returns a hit flag, the BAR number and the VF number two clock cycles after the request.

A second lookup path runs the other way. It takes the routing ID of a VF and a BAR number, and returns that VF's aperture base for the BAR. The VF number is found from the routing ID using the physical function's routing ID, the first-VF offset and the VF stride. The block is meant to sit next to the inbound request path of an endpoint that exposes VFs. Configuration inputs are expected to stay stable while lookups are in flight.

Top module: `vf_bar_decoder`

## Requirements
- R1: The aligned base of a BAR is its base register value with the low `size_log2` bits cleared. VF k owns the addresses from base + k·2^size_log2 up to and including base + (k+1)·2^size_log2 − 1. A request inside one of these apertures reports `hit`=1 with that BAR number and k as the VF number.
- R2: When `bar_is64[b]` is 1, the base of BAR b is {`bar_hi` dword, `bar_lo` dword}. When it is 0, the base is the zero-extended `bar_lo` dword, and the `bar_hi` dword has no effect on decoding.
- R3: Decoding produces no hit unless `vf_enable` and `vf_mem_enable` are both 1.
- R4: Only VF numbers below `num_vfs` can hit. `num_vfs` values above MAX_VF are treated as MAX_VF. An address below the aligned base, or past the last enabled VF's aperture, misses.
- R5: A BAR whose combined aperture, base + num_vfs·size, extends past 2^32 (32-bit BAR) or 2^64 (64-bit BAR) is unmapped. It never hits, and reverse lookups on it report not found.
- R6: `hit_valid` and `rev_valid` are asserted exactly two clock cycles after `req_valid` and `rev_req_valid` respectively, for one cycle per request.
- R7: When the request address lies inside apertures of several BARs, the lowest VF number wins. Between equal VF numbers, the lowest BAR number wins.
- R8: The reverse lookup sets `rev_found`=1 when `rev_rid` equals (`pf_rid` + `first_vf_offset` + k·`vf_stride`) mod 2^16 for some k below the effective VF count, and the selected BAR is mapped. In that case `rev_base` is the aligned base + k·2^size_log2. A routing ID that matches no such k gives `rev_found`=0.
- R9: While `rst` is high and in the first cycle after it, `hit_valid`, `hit`, `rev_valid` and `rev_found` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vf_enable | input | 1 | VF enable control bit |
| vf_mem_enable | input | 1 | VF memory space enable control bit |
| num_vfs | input | CNT_W | Active VF count |
| pf_rid | input | 16 | Routing ID of the physical function |
| first_vf_offset | input | 16 | Routing ID offset of VF 0 |
| vf_stride | input | 16 | Routing ID step between VFs |
| bar_lo | input | NUM_BARS·32 | Low dword of each VF BAR, BAR b at bits [32b+31:32b] |
| bar_hi | input | NUM_BARS·32 | High dword of each VF BAR |
| bar_is64 | input | NUM_BARS | 1 = BAR b is a 64-bit memory BAR |
| bar_size_log2 | input | NUM_BARS·6 | Size exponent of each BAR, BAR b at bits [6b+5:6b] |
| req_valid | input | 1 | Forward lookup request |
| req_addr | input | 64 | Request address |
| hit_valid | output | 1 | Forward result valid |
| hit | output | 1 | Address hits a VF aperture |
| hit_bar | output | BAR_W | BAR number of the hit |
| hit_vf | output | IDX_W | VF number of the hit |
| rev_req_valid | input | 1 | Reverse lookup request |
| rev_rid | input | 16 | VF routing ID to map |
| rev_bar | input | BAR_W | BAR to map |
| rev_valid | output | 1 | Reverse result valid |
| rev_found | output | 1 | Routing ID names an enabled VF on a mapped BAR |
| rev_base | output | 64 | Aperture base of that VF |

## Verification
Forward lookups use addresses at an aperture's first byte, in the middle of a later VF's aperture, one byte below the aligned base, and just past the last enabled VF. These separate the index arithmetic from the bounds check. A 64-bit BAR whose base has its low type bits set shows both that the upper dword is used and that the low bits are masked. A 32-bit BAR with garbage in its upper dword shows that the upper dword is ignored. Apertures of two BARs are made to overlap, both with different VF numbers and with equal ones, to separate the VF priority from the BAR priority. A wrapping BAR and each enable bit turned off in turn must all give misses. Reverse lookups use a matching routing ID, one that falls between two strides, and one at the first VF number past the count.

// File: rtl/vfdec_pkg.sv
package vfdec_pkg;
  localparam int ADDR_W = 64;
  localparam int RID_W  = 16;
  localparam int LOG_W  = 6;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [RID_W-1:0]  rid_t;
endpackage

// File: rtl/vfdec_bar_window.sv
module vfdec_bar_window
  import vfdec_pkg::*;
#(
  parameter int MAX_VF = 8,
  localparam int CNT_W = $clog2(MAX_VF + 1),
  localparam int IDX_W = (MAX_VF > 1) ? $clog2(MAX_VF) : 1
) (
  input  logic [31:0]      base_lo,
  input  logic [31:0]      base_hi,
  input  logic             is64,
  input  logic [LOG_W-1:0] size_log2,
  input  logic             dec_en,
  input  logic [CNT_W-1:0] vf_count,
  input  addr_t            addr,
  output logic             mapped,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output addr_t            base
);
  localparam int EXT_W = ADDR_W + 8;

  addr_t             raw;
  addr_t             offs;
  addr_t             quot;
  logic [EXT_W-1:0]  span;
  logic [EXT_W-1:0]  end_x;
  logic [EXT_W-1:0]  limit;

  always_comb begin
    raw    = is64 ? {base_hi, base_lo} : {32'b0, base_lo};
    base   = raw & ~((addr_t'(1) << size_log2) - addr_t'(1));
    span   = EXT_W'(vf_count) << size_log2;
    end_x  = EXT_W'(base) + span;
    limit  = is64 ? (EXT_W'(1) << 64) : (EXT_W'(1) << 32);
    mapped = dec_en && (vf_count != '0) && (end_x <= limit);
    offs   = addr - base;
    quot   = offs >> size_log2;
    hit    = mapped && (addr >= base) && (quot < ADDR_W'(vf_count));
    idx    = quot[IDX_W-1:0];
  end
endmodule

// File: rtl/vfdec_rid_index.sv
module vfdec_rid_index
  import vfdec_pkg::*;
#(
  parameter int MAX_VF = 8,
  localparam int CNT_W = $clog2(MAX_VF + 1),
  localparam int IDX_W = (MAX_VF > 1) ? $clog2(MAX_VF) : 1
) (
  input  rid_t             pf_rid,
  input  rid_t             first_off,
  input  rid_t             stride,
  input  logic [CNT_W-1:0] vf_count,
  input  rid_t             rid,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [MAX_VF-1:0] match;
  rid_t              first_rid;

  assign first_rid = pf_rid + first_off;

  for (genvar k = 0; k < MAX_VF; k++) begin : g_cand
    rid_t cand;
    assign cand     = first_rid + RID_W'(stride * RID_W'(k));
    assign match[k] = (rid == cand) && (CNT_W'(k) < vf_count);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = MAX_VF - 1; k >= 0; k--) begin
      if (match[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/vf_bar_decoder.sv
module vf_bar_decoder
  import vfdec_pkg::*;
#(
  parameter int NUM_BARS = 3,
  parameter int MAX_VF   = 8,
  localparam int CNT_W = $clog2(MAX_VF + 1),
  localparam int IDX_W = (MAX_VF > 1) ? $clog2(MAX_VF) : 1,
  localparam int BAR_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      vf_enable,
  input  logic                      vf_mem_enable,
  input  logic [CNT_W-1:0]          num_vfs,
  input  logic [15:0]               pf_rid,
  input  logic [15:0]               first_vf_offset,
  input  logic [15:0]               vf_stride,
  input  logic [NUM_BARS*32-1:0]    bar_lo,
  input  logic [NUM_BARS*32-1:0]    bar_hi,
  input  logic [NUM_BARS-1:0]       bar_is64,
  input  logic [NUM_BARS*LOG_W-1:0] bar_size_log2,
  input  logic                      req_valid,
  input  logic [63:0]               req_addr,
  output logic                      hit_valid,
  output logic                      hit,
  output logic [BAR_W-1:0]          hit_bar,
  output logic [IDX_W-1:0]          hit_vf,
  input  logic                      rev_req_valid,
  input  logic [15:0]               rev_rid,
  input  logic [BAR_W-1:0]          rev_bar,
  output logic                      rev_valid,
  output logic                      rev_found,
  output logic [63:0]               rev_base
);
  logic [CNT_W-1:0]    eff_cnt;
  logic                dec_en;
  logic [NUM_BARS-1:0] w_mapped;
  logic [NUM_BARS-1:0] w_hit;
  logic [IDX_W-1:0]    w_idx  [NUM_BARS];
  addr_t               w_base [NUM_BARS];

  assign eff_cnt = (num_vfs > CNT_W'(MAX_VF)) ? CNT_W'(MAX_VF) : num_vfs;
  assign dec_en  = vf_enable && vf_mem_enable;

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    vfdec_bar_window #(.MAX_VF(MAX_VF)) win_i (
      .base_lo  (bar_lo[b*32 +: 32]),
      .base_hi  (bar_hi[b*32 +: 32]),
      .is64     (bar_is64[b]),
      .size_log2(bar_size_log2[b*LOG_W +: LOG_W]),
      .dec_en   (dec_en),
      .vf_count (eff_cnt),
      .addr     (req_addr),
      .mapped   (w_mapped[b]),
      .hit      (w_hit[b]),
      .idx      (w_idx[b]),
      .base     (w_base[b])
    );
  end

  logic             rid_found;
  logic [IDX_W-1:0] rid_idx;

  vfdec_rid_index #(.MAX_VF(MAX_VF)) rid_i (
    .pf_rid   (pf_rid),
    .first_off(first_vf_offset),
    .stride   (vf_stride),
    .vf_count (eff_cnt),
    .rid      (rev_rid),
    .found    (rid_found),
    .idx      (rid_idx)
  );

  // Stage 1: per-BAR window results and reverse index.
  logic                s1_valid;
  logic [NUM_BARS-1:0] s1_hit;
  logic [IDX_W-1:0]    s1_idx [NUM_BARS];
  logic                r1_valid;
  logic                r1_found;
  logic [IDX_W-1:0]    r1_idx;
  logic [BAR_W-1:0]    r1_bar;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hit   <= '0;
      r1_valid <= 1'b0;
      r1_found <= 1'b0;
      r1_idx   <= '0;
      r1_bar   <= '0;
      for (int b = 0; b < NUM_BARS; b++) s1_idx[b] <= '0;
    end else begin
      s1_valid <= req_valid;
      s1_hit   <= req_valid ? w_hit : '0;
      for (int b = 0; b < NUM_BARS; b++) s1_idx[b] <= w_idx[b];
      r1_valid <= rev_req_valid;
      r1_found <= rev_req_valid && rid_found;
      r1_idx   <= rid_idx;
      r1_bar   <= rev_bar;
    end
  end

  // Stage 2: priority select (lowest VF, then lowest BAR) and reverse base.
  logic             sel_any;
  logic [BAR_W-1:0] sel_bar;
  logic [IDX_W-1:0] sel_idx;
  logic             rsel_ok;
  addr_t            rsel_base;
  logic [LOG_W-1:0] rsel_log;

  always_comb begin
    sel_any = 1'b0;
    sel_bar = '0;
    sel_idx = '0;
    for (int b = 0; b < NUM_BARS; b++) begin
      if (s1_hit[b] && (!sel_any || (s1_idx[b] < sel_idx))) begin
        sel_any = 1'b1;
        sel_bar = BAR_W'(b);
        sel_idx = s1_idx[b];
      end
    end
  end

  always_comb begin
    rsel_ok   = 1'b0;
    rsel_base = '0;
    rsel_log  = '0;
    for (int b = 0; b < NUM_BARS; b++) begin
      if (BAR_W'(b) == r1_bar) begin
        rsel_ok   = w_mapped[b];
        rsel_base = w_base[b];
        rsel_log  = bar_size_log2[b*LOG_W +: LOG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit       <= 1'b0;
      hit_bar   <= '0;
      hit_vf    <= '0;
      rev_valid <= 1'b0;
      rev_found <= 1'b0;
      rev_base  <= '0;
    end else begin
      hit_valid <= s1_valid;
      hit       <= sel_any;
      hit_bar   <= sel_bar;
      hit_vf    <= sel_idx;
      rev_valid <= r1_valid;
      rev_found <= r1_found && rsel_ok;
      rev_base  <= rsel_base + (ADDR_W'(r1_idx) << rsel_log);
    end
  end
endmodule

// File: rtl/vf_bar_decoder_chk.sv
module vf_bar_decoder_chk #(
  parameter int MAX_VF = 8,
  localparam int CNT_W = $clog2(MAX_VF + 1),
  localparam int IDX_W = (MAX_VF > 1) ? $clog2(MAX_VF) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             vf_enable,
  input logic             vf_mem_enable,
  input logic [CNT_W-1:0] num_vfs,
  input logic             req_valid,
  input logic             rev_req_valid,
  input logic             hit_valid,
  input logic             hit,
  input logic [IDX_W-1:0] hit_vf,
  input logic             rev_valid,
  input logic             rev_found
);
  logic             en_q1, en_q2;
  logic [CNT_W-1:0] cnt_q1, cnt_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q1  <= 1'b0;
      en_q2  <= 1'b0;
      cnt_q1 <= '0;
      cnt_q2 <= '0;
    end else begin
      en_q1  <= vf_enable && vf_mem_enable;
      en_q2  <= en_q1;
      cnt_q1 <= num_vfs;
      cnt_q2 <= cnt_q1;
    end
  end

  p_fwd_latency_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 hit_valid);

  p_rev_latency_r6: assert property (@(posedge clk) disable iff (rst)
    rev_req_valid |-> ##2 rev_valid);

  p_hit_needs_enable_r3: assert property (@(posedge clk) disable iff (rst)
    hit |-> en_q2);

  p_hit_vf_range_r4: assert property (@(posedge clk) disable iff (rst)
    hit |-> (int'(hit_vf) < int'(cnt_q2)));

  p_hit_has_valid_r1: assert property (@(posedge clk) disable iff (rst)
    hit |-> hit_valid);

  p_rev_found_valid_r8: assert property (@(posedge clk) disable iff (rst)
    rev_found |-> rev_valid);
endmodule

bind vf_bar_decoder vf_bar_decoder_chk #(.MAX_VF(MAX_VF)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .vf_enable    (vf_enable),
  .vf_mem_enable(vf_mem_enable),
  .num_vfs      (num_vfs),
  .req_valid    (req_valid),
  .rev_req_valid(rev_req_valid),
  .hit_valid    (hit_valid),
  .hit          (hit),
  .hit_vf       (hit_vf),
  .rev_valid    (rev_valid),
  .rev_found    (rev_found)
);

// File: tb/vf_bar_decoder_tb_top.sv
module vf_bar_decoder_tb_top;
  localparam int NB = 3;
  localparam int MV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vf_enable = 1'b1, vf_mem_enable = 1'b1;
  logic [3:0]  num_vfs = 4'd4;
  logic [15:0] pf_rid = 16'h0100, first_vf_offset = 16'd4, vf_stride = 16'd2;
  logic [NB*32-1:0] bar_lo, bar_hi;
  logic [NB-1:0]    bar_is64;
  logic [NB*6-1:0]  bar_size_log2;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        hit_valid, hit;
  logic [1:0]  hit_bar;
  logic [2:0]  hit_vf;
  logic        rev_req_valid = 1'b0;
  logic [15:0] rev_rid = '0;
  logic [1:0]  rev_bar = '0;
  logic        rev_valid, rev_found;
  logic [63:0] rev_base;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vf_bar_decoder #(.NUM_BARS(NB), .MAX_VF(MV)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_bar(input int b, input logic [31:0] lo, input logic [31:0] hi,
                         input logic is64, input logic [5:0] lg);
    @(negedge clk);
    bar_lo[b*32 +: 32] = lo;
    bar_hi[b*32 +: 32] = hi;
    bar_is64[b] = is64;
    bar_size_log2[b*6 +: 6] = lg;
  endtask

  task automatic fwd(input logic [63:0] a, input bit e_hit, input logic [1:0] e_bar,
                     input logic [2:0] e_vf, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(hit_valid == 1'b0, {tag, " R6 early"}, 64'(hit_valid), 64'd0);
    @(negedge clk);
    chk(hit_valid == 1'b1, {tag, " R6 valid"}, 64'(hit_valid), 64'd1);
    chk(hit == e_hit, {tag, " hit"}, 64'(hit), 64'(e_hit));
    if (e_hit) begin
      chk(hit_bar == e_bar, {tag, " bar"}, 64'(hit_bar), 64'(e_bar));
      chk(hit_vf == e_vf, {tag, " vf"}, 64'(hit_vf), 64'(e_vf));
    end
  endtask

  task automatic rev(input logic [15:0] rid, input logic [1:0] b, input bit e_found,
                     input logic [63:0] e_base, input string tag);
    @(negedge clk);
    rev_req_valid = 1'b1;
    rev_rid = rid;
    rev_bar = b;
    @(negedge clk);
    rev_req_valid = 1'b0;
    @(negedge clk);
    chk(rev_valid == 1'b1, {tag, " R6 rev valid"}, 64'(rev_valid), 64'd1);
    chk(rev_found == e_found, {tag, " found"}, 64'(rev_found), 64'(e_found));
    if (e_found) chk(rev_base == e_base, {tag, " base"}, rev_base, e_base);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!hit_valid && !hit && !rev_valid && !rev_found, "R9 reset outputs",
        64'({hit_valid, hit, rev_valid, rev_found}), 64'd0);
  endtask

  task automatic t_basic();
    fwd(64'h8000_0000, 1, 2'd0, 3'd0, "R1 first byte vf0");
    fwd(64'h8000_2010, 1, 2'd0, 3'd2, "R1 mid vf2");
    fwd(64'h7FFF_FFFF, 0, 2'd0, 3'd0, "R4 below base");
    fwd(64'h8000_4000, 0, 2'd0, 3'd0, "R4 past last vf");
  endtask

  task automatic t_width();
    fwd(64'h1_4003_0000, 1, 2'd1, 3'd3, "R2 64-bit base masked");
    fwd(64'h0000_DEAD_8000_0000, 0, 2'd0, 3'd0, "R2 32-bit ignores hi");
  endtask

  task automatic t_wrap();
    fwd(64'hFFF0_0000, 0, 2'd0, 3'd0, "R5 wrapping BAR miss");
    rev(16'h0104, 2'd2, 0, 64'd0, "R5 wrapping BAR rev");
  endtask

  task automatic t_enables();
    @(negedge clk); vf_mem_enable = 1'b0;
    fwd(64'h8000_0000, 0, 2'd0, 3'd0, "R3 mem enable off");
    @(negedge clk); vf_mem_enable = 1'b1; vf_enable = 1'b0;
    fwd(64'h8000_0000, 0, 2'd0, 3'd0, "R3 vf enable off");
    @(negedge clk); vf_enable = 1'b1;
  endtask

  task automatic t_priority();
    set_bar(2, 32'h8000_1000, 32'h0, 1'b0, 6'd12);
    fwd(64'h8000_2000, 1, 2'd2, 3'd1, "R7 lowest vf wins");
    set_bar(2, 32'h8000_0000, 32'h0, 1'b0, 6'd12);
    fwd(64'h8000_2000, 1, 2'd0, 3'd2, "R7 tie lowest bar");
  endtask

  task automatic t_reverse();
    rev(16'h0108, 2'd1, 1, 64'h1_4002_0000, "R8 rid vf2 bar1");
    rev(16'h0104, 2'd0, 1, 64'h8000_0000, "R8 rid vf0 bar0");
    rev(16'h0105, 2'd0, 0, 64'd0, "R8 rid between strides");
    rev(16'h010C, 2'd0, 0, 64'd0, "R8 rid past count");
  endtask

  task automatic t_count_clamp();
    @(negedge clk); num_vfs = 4'd15;
    fwd(64'h8000_7000, 1, 2'd0, 3'd7, "R4 clamp highest vf");
    fwd(64'h8000_8000, 0, 2'd0, 3'd0, "R4 clamp beyond max");
    @(negedge clk); num_vfs = 4'd4;
  endtask

  initial begin
    bar_lo = '0; bar_hi = '0; bar_is64 = '0; bar_size_log2 = '0;
    bar_lo[0 +: 32] = 32'h8000_0000; bar_hi[0 +: 32] = 32'h0000_DEAD;
    bar_size_log2[0 +: 6] = 6'd12;
    bar_lo[32 +: 32] = 32'h4000_000C; bar_hi[32 +: 32] = 32'h1;
    bar_is64[1] = 1'b1; bar_size_log2[6 +: 6] = 6'd16;
    bar_lo[64 +: 32] = 32'hFFF0_0000; bar_size_log2[12 +: 6] = 6'd20;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_basic();
    t_width();
    t_wrap();
    t_enables();
    t_reverse();
    t_priority();
    t_count_clamp();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule